// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block is the command engine of a multi-slot hot-plug controller. Software hands it one 16-bit command word at a time. The low byte is the operation code and the high byte is the target slot. The engine takes the word on a valid/ready handshake and holds busy for a programmable number of cycles. When that time is up it decodes the word against the live mechanical-latch sensors and the interface revision. In the same clock it applies the result, latches a 3-bit error code and pulses a one-cycle completion event.

The result can be one of three things. It can update the state, power-indicator and attention-indicator fields of one slot. It can put every slot into the powered or enabled state at once. It can load the 4-bit bus speed/mode register. Back-pressure is simple: `cmd_ready` is low for the whole busy window. A word presented while ready is low is not taken and leaves no trace. The source may hold `cmd_valid` high, and the word is accepted on the first cycle that ready returns.

Top module: `hp_cmd_engine`

## Requirements
- R1: After reset, busy and the error code are 0, `cmd_done` is 0 and `cmd_ready` is 1. Every slot state field reads 3 (disabled), every indicator field reads 3 (off), and the speed/mode register reads 0.
- R2: A word is accepted when `cmd_valid` and `cmd_ready` are both high. Busy (status bit 0) rises in the next cycle and stays high for `busy_cycles` cycles, with a value of 0 treated as 1. `cmd_ready` is the inverse of busy.
- R3: While busy, a presented word is ignored. It changes no slot field, no speed value and no error code, and it starts no second busy window.
- R4: Codes 00h–3Fh act on the slot in bits [15:8], counted from 1, where slot 1 maps to output bits [1:0]. Code bits [1:0] set the state (1 power-only, 2 enabled, 3 disabled). Bits [3:2] set the power indicator and bits [5:4] set the attention indicator (1 on, 2 blink, 3 off). A zero field leaves that field unchanged.
- R5: A slot-operation code whose slot number is 0 or greater than `NUM_SLOTS` reports invalid command (status[3:1] = 3'b010) and changes no slot.
- R6: A slot-operation code that asks for state 1 or 2 on a slot whose latch input is open reports switch open (3'b001) and leaves all three fields of that slot unchanged. A state field of 0 or 3 on an open slot is carried out.
- R7: Codes 40h–44h load the speed/mode register with code − 40h. Codes 45h–47h and 5Eh–5Fh report invalid speed/mode (3'b100) and leave the speed unchanged.
- R8: Code 48h sets every slot to power-only and 49h sets every slot to enabled. Slots whose latch is open are skipped, and if any slot is skipped the code is switch open (3'b001).
- R9: Codes 50h–5Dh load the speed/mode register with code bits [3:0] when `rev2_if` is 1. When it is 0 they report invalid speed/mode and leave the speed unchanged, so the register then only moves within 0–4.
- R10: Codes 4Ah–4Fh and 60h–FFh report invalid command and change no slot or speed state.
- R11: The error code is cleared when a word is accepted. It is loaded at completion and held until the next word is accepted. At most one error bit is ever set.
- R12: `cmd_done` is high for exactly one cycle, the first cycle in which busy is low again. Slot, speed and error outputs take their new values in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine idle, word will be taken |
| cmd_word | input | 16 | [15:8] slot number, [7:0] operation code |
| busy_cycles | input | LEN_W | Busy window length in cycles (0 acts as 1) |
| rev2_if | input | 1 | 1 = interface revision 2 (speed/mode B allowed) |
| latch_open | input | NUM_SLOTS | Per-slot mechanical latch open sensor |
| status | output | 4 | [0] busy, [3:1] error code |
| slot_state | output | 2*NUM_SLOTS | Per-slot state field |
| pwr_led | output | 2*NUM_SLOTS | Per-slot power indicator field |
| attn_led | output | 2*NUM_SLOTS | Per-slot attention indicator field |
| speed_mode | output | 4 | Current bus speed/mode code |
| cmd_done | output | 1 | One-cycle completion event |

## Verification
Every result of a command is due a fixed number of cycles after acceptance: busy in the next cycle, then `busy_cycles` busy cycles, then completion. The checks sample on falling edges. They count busy cycles from the first falling edge after the accepting rising edge, and they read slot fields, speed and error code at the first falling edge where busy is low. At that same edge `cmd_done` must be high, and it must be low one edge later. The ignored-while-busy case holds a second word on the port through most of the busy window. It then checks that busy is low one edge after completion and that only the first word's effect is visible.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  localparam logic [2:0] ERR_NONE   = 3'b000;
  localparam logic [2:0] ERR_SWITCH = 3'b001;
  localparam logic [2:0] ERR_BADCMD = 3'b010;
  localparam logic [2:0] ERR_BADSPD = 3'b100;

  typedef enum logic [2:0] {
    CLS_SLOT,
    CLS_SPD_A,
    CLS_RSV_SPD,
    CLS_ALL_PWR,
    CLS_ALL_EN,
    CLS_SPD_B,
    CLS_BAD
  } cmd_class_e;

  function automatic cmd_class_e classify(input logic [7:0] code);
    cmd_class_e c;
    if (code < 8'h40)                        c = CLS_SLOT;
    else if (code <= 8'h44)                  c = CLS_SPD_A;
    else if (code <= 8'h47)                  c = CLS_RSV_SPD;
    else if (code == 8'h48)                  c = CLS_ALL_PWR;
    else if (code == 8'h49)                  c = CLS_ALL_EN;
    else if (code >= 8'h50 && code <= 8'h5D) c = CLS_SPD_B;
    else if (code == 8'h5E || code == 8'h5F) c = CLS_RSV_SPD;
    else                                     c = CLS_BAD;
    return c;
  endfunction

endpackage

// File: rtl/hpc_busy_timer.sv
module hpc_busy_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             finish
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q;
  logic             busy_q;

  assign busy   = busy_q;
  assign finish = busy_q && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= (len == '0) ? ONE : len;
    end else if (busy_q) begin
      if (cnt_q == ONE) busy_q <= 1'b0;
      else              cnt_q  <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 8
) (
  input  logic [15:0]          cmd_word,
  input  logic [NUM_SLOTS-1:0] latch_open,
  input  logic                 rev2_if,
  output logic [2:0]           err,
  output logic                 spd_we,
  output logic [3:0]           spd_val,
  output logic [NUM_SLOTS-1:0] slot_we,
  output logic [1:0]           st_val,
  output logic [1:0]           pw_val,
  output logic [1:0]           at_val
);
  localparam logic [SLOT_W-1:0] MAX_SLOT = SLOT_W'(NUM_SLOTS);

  logic [7:0]           code;
  logic [SLOT_W-1:0]    slot_no;
  logic [NUM_SLOTS-1:0] sel;
  logic                 open_hit;
  logic                 wants_power;

  assign code    = cmd_word[7:0];
  assign slot_no = cmd_word[15:8];

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      sel[i] = (slot_no == SLOT_W'(i + 1));
  end

  assign open_hit    = |(sel & latch_open);
  assign wants_power = (code[1:0] == 2'd1) || (code[1:0] == 2'd2);

  always_comb begin
    err     = ERR_NONE;
    spd_we  = 1'b0;
    spd_val = 4'd0;
    slot_we = '0;
    st_val  = 2'd0;
    pw_val  = 2'd0;
    at_val  = 2'd0;
    unique case (classify(code))
      CLS_SLOT: begin
        if (slot_no == '0 || slot_no > MAX_SLOT) begin
          err = ERR_BADCMD;
        end else if (open_hit && wants_power) begin
          err = ERR_SWITCH;
        end else begin
          slot_we = sel;
          st_val  = code[1:0];
          pw_val  = code[3:2];
          at_val  = code[5:4];
        end
      end
      CLS_SPD_A: begin
        spd_we  = 1'b1;
        spd_val = {1'b0, code[2:0]};
      end
      CLS_RSV_SPD: err = ERR_BADSPD;
      CLS_ALL_PWR, CLS_ALL_EN: begin
        slot_we = ~latch_open;
        st_val  = (classify(code) == CLS_ALL_EN) ? 2'd2 : 2'd1;
        if (|latch_open) err = ERR_SWITCH;
      end
      CLS_SPD_B: begin
        if (rev2_if) begin
          spd_we  = 1'b1;
          spd_val = code[3:0];
        end else begin
          err = ERR_BADSPD;
        end
      end
      default: err = ERR_BADCMD;
    endcase
  end
endmodule

// File: rtl/hpc_slot_bank.sv
module hpc_slot_bank #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   apply,
  input  logic [NUM_SLOTS-1:0]   slot_we,
  input  logic [1:0]             st_val,
  input  logic [1:0]             pw_val,
  input  logic [1:0]             at_val,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] pwr_led,
  output logic [2*NUM_SLOTS-1:0] attn_led
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [1:0] st_q, pw_q, at_q;
    logic       hit;

    assign hit = apply && slot_we[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= 2'd3;
        pw_q <= 2'd3;
        at_q <= 2'd3;
      end else if (hit) begin
        if (st_val != 2'd0) st_q <= st_val;
        if (pw_val != 2'd0) pw_q <= pw_val;
        if (at_val != 2'd0) at_q <= at_val;
      end
    end

    assign slot_state[2*g +: 2] = st_q;
    assign pwr_led[2*g +: 2]    = pw_q;
    assign attn_led[2*g +: 2]   = at_q;
  end
endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
  import hpc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LEN_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [15:0]            cmd_word,
  input  logic [LEN_W-1:0]       busy_cycles,
  input  logic                   rev2_if,
  input  logic [NUM_SLOTS-1:0]   latch_open,
  output logic [3:0]             status,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] pwr_led,
  output logic [2*NUM_SLOTS-1:0] attn_led,
  output logic [3:0]             speed_mode,
  output logic                   cmd_done
);
  logic                 busy, finish, accept;
  logic [15:0]          word_q;
  logic [2:0]           err_q, dec_err;
  logic [3:0]           spd_q, dec_spd;
  logic                 dec_spd_we, done_q;
  logic [NUM_SLOTS-1:0] dec_slot_we;
  logic [1:0]           dec_st, dec_pw, dec_at;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;

  hpc_busy_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .len(busy_cycles),
    .busy(busy), .finish(finish)
  );

  hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .cmd_word(word_q), .latch_open(latch_open), .rev2_if(rev2_if),
    .err(dec_err), .spd_we(dec_spd_we), .spd_val(dec_spd),
    .slot_we(dec_slot_we), .st_val(dec_st), .pw_val(dec_pw), .at_val(dec_at)
  );

  hpc_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .apply(finish), .slot_we(dec_slot_we),
    .st_val(dec_st), .pw_val(dec_pw), .at_val(dec_at),
    .slot_state(slot_state), .pwr_led(pwr_led), .attn_led(attn_led)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      err_q  <= ERR_NONE;
      spd_q  <= 4'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        word_q <= cmd_word;
        err_q  <= ERR_NONE;
      end else if (finish) begin
        err_q <= dec_err;
        if (dec_spd_we) spd_q <= dec_spd;
      end
    end
  end

  assign status     = {err_q, busy};
  assign speed_mode = spd_q;
  assign cmd_done   = done_q;
endmodule

// File: rtl/hp_cmd_engine_chk.sv
module hp_cmd_engine_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   rev2_if,
  input logic [3:0]             status,
  input logic [2*NUM_SLOTS-1:0] slot_state,
  input logic [3:0]             speed_mode,
  input logic                   cmd_done
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> status[0]);

  a_r3_slots_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |=> (cmd_done || $stable(slot_state)));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!status[0] && $past(status[0])));

  a_r11_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (status[3:1] == 3'b000));

  a_r11_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[3:1]));

  a_r9_rev1_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !rev2_if && !$stable(speed_mode)) |-> (speed_mode <= 4'd4));
endmodule

bind hp_cmd_engine hp_cmd_engine_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rev2_if(rev2_if), .status(status), .slot_state(slot_state),
  .speed_mode(speed_mode), .cmd_done(cmd_done)
);

// File: tb/hp_cmd_engine_test.sv
module hp_cmd_engine_test;
  localparam int N = 4;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [15:0]   cmd_word = '0;
  logic [LW-1:0] busy_cycles = 8'd3;
  logic          rev2_if = 1'b1;
  logic [N-1:0]  latch_open = '0;
  logic [3:0]    status;
  logic [2*N-1:0] slot_state, pwr_led, attn_led;
  logic [3:0]    speed_mode;
  logic          cmd_done;

  int n_chk = 0;
  int n_fail = 0;
  int cur_len = 3;

  always #5 clk = ~clk;

  hp_cmd_engine #(.NUM_SLOTS(N), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .busy_cycles(busy_cycles), .rev2_if(rev2_if),
    .latch_open(latch_open), .status(status), .slot_state(slot_state),
    .pwr_led(pwr_led), .attn_led(attn_led), .speed_mode(speed_mode),
    .cmd_done(cmd_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Offer one word while idle; checks R2 busy length, R11 clear, R12 pulse.
  task automatic issue(input logic [15:0] w);
    int busy_n = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 error cleared while busy", {29'd0, status[3:1]}, 32'd0);
    while (status[0] && busy_n < 300) begin
      busy_n++;
      @(negedge clk);
    end
    chk("R2 busy window length", busy_n, cur_len);
    chk("R12 done with busy low", {31'd0, cmd_done}, 32'd1);
    @(negedge clk);
    chk("R12 done one cycle", {31'd0, cmd_done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 status", {28'd0, status}, 32'd0);
    chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1 done", {31'd0, cmd_done}, 32'd0);
    chk("R1 slot state", {24'd0, slot_state}, 32'hFF);
    chk("R1 power led", {24'd0, pwr_led}, 32'hFF);
    chk("R1 attn led", {24'd0, attn_led}, 32'hFF);
    chk("R1 speed", {28'd0, speed_mode}, 32'd0);
  endtask

  task automatic t_slot_fields;
    issue(16'h013A);
    chk("R4 state", {24'd0, slot_state}, 32'hFE);
    chk("R4 power led", {24'd0, pwr_led}, 32'hFE);
    chk("R4 attn led", {24'd0, attn_led}, 32'hFF);
    chk("R4 no error", {29'd0, status[3:1]}, 32'd0);
    issue(16'h0110);
    chk("R4 zero field keeps state", {24'd0, slot_state}, 32'hFE);
    chk("R4 zero field keeps power", {24'd0, pwr_led}, 32'hFE);
    chk("R4 attn on", {24'd0, attn_led}, 32'hFD);
  endtask

  task automatic t_bad_slot;
    issue(16'h0001);
    chk("R5 slot 0 error", {29'd0, status[3:1]}, 32'd2);
    chk("R5 slot 0 no change", {24'd0, slot_state}, 32'hFE);
    issue(16'h0501);
    chk("R5 slot 5 error", {29'd0, status[3:1]}, 32'd2);
    chk("R5 slot 5 no change", {24'd0, slot_state}, 32'hFE);
  endtask

  task automatic t_latch;
    latch_open = 4'b0010;
    issue(16'h0231);
    chk("R6 switch open error", {29'd0, status[3:1]}, 32'd1);
    chk("R6 state unchanged", {24'd0, slot_state}, 32'hFE);
    chk("R6 attn unchanged", {24'd0, attn_led}, 32'hFD);
    issue(16'h0223);
    chk("R6 disable allowed", {29'd0, status[3:1]}, 32'd0);
    chk("R6 attn blink applied", {24'd0, attn_led}, 32'hF9);
    latch_open = 4'b0000;
  endtask

  task automatic t_speed;
    issue(16'h0043);
    chk("R7 speed A", {28'd0, speed_mode}, 32'd3);
    issue(16'h0046);
    chk("R7 reserved A error", {29'd0, status[3:1]}, 32'd4);
    chk("R7 reserved keeps speed", {28'd0, speed_mode}, 32'd3);
    rev2_if = 1'b0;
    issue(16'h0057);
    chk("R9 rev1 rejects B", {29'd0, status[3:1]}, 32'd4);
    chk("R9 rev1 keeps speed", {28'd0, speed_mode}, 32'd3);
    issue(16'h0044);
    chk("R9 rev1 accepts A", {28'd0, speed_mode}, 32'd4);
    rev2_if = 1'b1;
    issue(16'h0057);
    chk("R9 rev2 B ecc", {28'd0, speed_mode}, 32'd7);
    issue(16'h005D);
    chk("R9 rev2 B 533", {28'd0, speed_mode}, 32'hD);
    issue(16'h005E);
    chk("R7 reserved B error", {29'd0, status[3:1]}, 32'd4);
    chk("R7 reserved B keeps", {28'd0, speed_mode}, 32'hD);
  endtask

  task automatic t_all_slots;
    latch_open = 4'b0010;
    issue(16'h0049);
    chk("R8 enable all skips open", {24'd0, slot_state}, 32'hAE);
    chk("R8 switch open error", {29'd0, status[3:1]}, 32'd1);
    latch_open = 4'b0000;
    issue(16'h0048);
    chk("R8 power-only all", {24'd0, slot_state}, 32'h55);
    chk("R8 no error", {29'd0, status[3:1]}, 32'd0);
  endtask

  task automatic t_bad_codes;
    issue(16'h0060);
    chk("R10 60h invalid", {29'd0, status[3:1]}, 32'd2);
    issue(16'h00C5);
    chk("R10 C5h invalid", {29'd0, status[3:1]}, 32'd2);
    issue(16'h014B);
    chk("R10 4Bh invalid", {29'd0, status[3:1]}, 32'd2);
    chk("R10 slots unchanged", {24'd0, slot_state}, 32'h55);
    chk("R10 speed unchanged", {28'd0, speed_mode}, 32'hD);
    issue(16'h0043);
    chk("R11 error cleared by good word", {29'd0, status[3:1]}, 32'd0);
  endtask

  task automatic t_busy_ignore;
    int guard = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = 16'h0302;
    @(negedge clk);
    cmd_word  = 16'h0403;
    chk("R3 ready low while busy", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (status[0] && guard < 300) begin
      guard++;
      @(negedge clk);
    end
    chk("R3 first word applied", {24'd0, slot_state}, 32'h65);
    @(negedge clk);
    chk("R3 no second window", {31'd0, status[0]}, 32'd0);
    chk("R3 second word dropped", {24'd0, slot_state}, 32'h65);
  endtask

  task automatic t_lengths;
    busy_cycles = 8'd0;
    cur_len = 1;
    issue(16'h0104);
    chk("R2 zero length power led", {24'd0, pwr_led}, 32'hFD);
    busy_cycles = 8'd5;
    cur_len = 5;
    issue(16'h0042);
    chk("R2 long window speed", {28'd0, speed_mode}, 32'd2);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slot_fields();
    t_bad_slot();
    t_latch();
    t_speed();
    t_all_slots();
    t_bad_codes();
    t_busy_ignore();
    t_lengths();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule